// File: doc/BRIEF.md
# Priority Interrupt Vector Generator

This block turns a set of conversion-ready flags into one interrupt vector address. Two 32-bit status words are joined into a single 64-entry ready set: bit i of the low word is input ID i, and bit j of the high word is input ID 32+j. The block picks the lowest-numbered set flag, shifts its ID left by a programmed amount of 0 to 7 bits, and adds the result to a programmed base address. Software reads the sum as the vector, and a valid flag says whether any flag was set.

The base address and the shift amount sit in two configuration registers. They are loaded through a single-cycle write port, with `cfg_sel` choosing the register. The vector and the valid flag are registered. There is no state machine. The datapath is combinational priority selection followed by a shift and an add, then one output register stage.

Top module: `piv_vector_gen`

## Requirements
- R1: Among all set ready bits, the smallest input ID wins. Bit i of `stat_lo` is ID i and bit j of `stat_hi` is ID 32+j, so every set bit of `stat_lo` beats every set bit of `stat_hi`.
- R2: While any ready bit is set, `vec_valid` is 1 and `vec_addr` equals base + (winning ID << shift).
- R3: Each shift value n from 0 to 7 moves the winning ID left by exactly n bit positions.
- R4: While no ready bit is set, `vec_valid` is 0 and `vec_addr` equals the programmed base unchanged.
- R5: The outputs are registered. The status words are sampled at a rising clock edge, and the result appears on the outputs right after that same edge.
- R6: A write with `cfg_wr_en`=1 loads the base from `cfg_wdata` when `cfg_sel`=0. When `cfg_sel`=1 it loads the shift from `cfg_wdata[2:0]` and ignores bits 31:3. The new value is used by the outputs from the edge that follows the write edge.
- R7: Reset (`rst_n`=0) clears the base to 0, the shift to 0, `vec_valid` to 0 and `vec_addr` to 0.
- R8: The addition wraps modulo 2^32.
- R9: While `cfg_wr_en`=0, neither the base nor the shift changes, whatever `cfg_sel` and `cfg_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_lo | input | 32 | Ready flags for IDs 0..31 |
| stat_hi | input | 32 | Ready flags for IDs 32..63 |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the base register, 1 selects the shift register |
| cfg_wdata | input | 32 | Configuration write data |
| vec_addr | output | 32 | Base plus the shifted winning ID |
| vec_valid | output | 1 | At least one ready flag was set |

## Verification
Status words driven before a rising edge must show on the outputs just after that edge. A configuration write captured at an edge does not affect the result computed at that same edge; it affects the result of the next edge. The bench drives every input on the falling edge and samples the outputs one time unit after the next rising edge. Its model always uses the configuration held before the current edge, and it applies any write only after the compare. Together these choices check both latencies on every cycle, in the directed corner cases and in the random run alike.

// File: rtl/piv_pkg.sv
package piv_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int ADDR_W    = 32;
    localparam int SHIFT_W   = 3;
    localparam int NUM_IN    = WORD_W * NUM_WORDS;
    localparam int ID_W      = $clog2(NUM_IN);
    localparam int LOC_W     = $clog2(WORD_W);

    typedef enum logic {
        CFG_BASE  = 1'b0,
        CFG_SHIFT = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/piv_word_enc.sv
module piv_word_enc #(
    parameter int WORD_W = 32,
    localparam int LOC_W = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] word,
    output logic              hit,
    output logic [LOC_W-1:0]  loc
);
    always_comb begin
        hit = |word;
        loc = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (word[i]) begin
                loc = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/piv_prio_sel.sv
module piv_prio_sel #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 2,
    localparam int NUM_IN   = WORD_W * NUM_WORDS,
    localparam int ID_W     = $clog2(NUM_IN),
    localparam int LOC_W    = $clog2(WORD_W)
) (
    input  logic [NUM_IN-1:0] bits,
    output logic              any_hit,
    output logic [ID_W-1:0]   win_id
);
    logic [NUM_WORDS-1:0] word_hit;
    logic [LOC_W-1:0]     word_loc [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        piv_word_enc #(.WORD_W(WORD_W)) u_enc (
            .word (bits[w*WORD_W +: WORD_W]),
            .hit  (word_hit[w]),
            .loc  (word_loc[w])
        );
    end

    // Lower word index wins, so the scan runs downward and the last hit stays.
    always_comb begin
        any_hit = |word_hit;
        win_id  = '0;
        for (int w = NUM_WORDS - 1; w >= 0; w--) begin
            if (word_hit[w]) begin
                win_id = ID_W'(w * WORD_W) + ID_W'(word_loc[w]);
            end
        end
    end
endmodule

// File: rtl/piv_cfg_regs.sv
module piv_cfg_regs
    import piv_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  cfg_sel_e           wr_sel,
    input  logic [ADDR_W-1:0]  wr_data,
    output logic [ADDR_W-1:0]  base_q,
    output logic [SHIFT_W-1:0] shift_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            shift_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                CFG_BASE:  base_q  <= wr_data;
                CFG_SHIFT: shift_q <= wr_data[SHIFT_W-1:0];
            endcase
        end
    end

    // R9: registers only move on a strobe
    a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(base_q));
    a_r9_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shift_q));
    // R6: a shift write lands only the low bits
    a_r6_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == CFG_SHIFT) |=> shift_q == $past(wr_data[SHIFT_W-1:0]));
endmodule

// File: rtl/piv_vec_calc.sv
module piv_vec_calc #(
    parameter int ADDR_W  = 32,
    parameter int SHIFT_W = 3,
    parameter int ID_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit,
    input  logic [ID_W-1:0]    id,
    input  logic [ADDR_W-1:0]  base,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               vec_valid
);
    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] sum;
    logic              armed;

    always_comb begin
        offset = hit ? (ADDR_W'(id) << shift) : '0;
        sum    = base + offset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr  <= '0;
            vec_valid <= 1'b0;
            armed     <= 1'b0;
        end else begin
            vec_addr  <= sum;
            vec_valid <= hit;
            armed     <= 1'b1;
        end
    end

    // R4: idle output equals the base of the previous cycle
    a_r4_idle_base: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !vec_valid) |-> vec_addr == $past(base));
    // R2/R3: the offset above the base is a multiple of 2^shift
    a_r3_shift_align: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (((vec_addr - $past(base)) & ((ADDR_W'(1) << $past(shift)) - 1'b1)) == '0));
endmodule

// File: rtl/piv_vector_gen.sv
module piv_vector_gen
    import piv_pkg::*;
#(
    parameter int WORD_W  = piv_pkg::WORD_W,
    parameter int ADDR_W  = piv_pkg::ADDR_W,
    parameter int SHIFT_W = piv_pkg::SHIFT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] stat_lo,
    input  logic [WORD_W-1:0] stat_hi,
    input  logic              cfg_wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              vec_valid
);
    localparam int N_WORDS = 2;
    localparam int N_IN    = WORD_W * N_WORDS;
    localparam int IDW     = $clog2(N_IN);

    logic [N_IN-1:0]    all_bits;
    logic               win_hit;
    logic [IDW-1:0]     win_id;
    logic [ADDR_W-1:0]  base_q;
    logic [SHIFT_W-1:0] shift_q;
    cfg_sel_e           sel_e;
    logic               armed;

    assign all_bits = {stat_hi, stat_lo};
    assign sel_e    = cfg_sel_e'(cfg_sel);

    piv_prio_sel #(.WORD_W(WORD_W), .NUM_WORDS(N_WORDS)) u_sel (
        .bits    (all_bits),
        .any_hit (win_hit),
        .win_id  (win_id)
    );

    piv_cfg_regs #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (sel_e),
        .wr_data (cfg_wdata),
        .base_q  (base_q),
        .shift_q (shift_q)
    );

    piv_vec_calc #(.ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W), .ID_W(IDW)) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (win_hit),
        .id        (win_id),
        .base      (base_q),
        .shift     (shift_q),
        .vec_addr  (vec_addr),
        .vec_valid (vec_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R1: the winner is a set bit and nothing below it is set
    a_r1_winner_set: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> all_bits[win_id]);
    a_r1_none_below: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit |-> ((all_bits & ((N_IN'(1) << win_id) - 1'b1)) == '0));
    // R5: valid follows the status words one edge later
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> vec_valid == $past(|all_bits));
endmodule

// File: tb/piv_vector_gen_tb.sv
module piv_vector_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] stat_lo = '0;
    logic [31:0] stat_hi = '0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] vec_addr;
    logic        vec_valid;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] base_m = '0;
    logic [2:0]  sh_m = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    piv_vector_gen u_dut (
        .clk(clk), .rst_n(rst_n), .stat_lo(stat_lo), .stat_hi(stat_hi),
        .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .vec_addr(vec_addr), .vec_valid(vec_valid)
    );

    function automatic logic [32:0] model(logic [31:0] lo, logic [31:0] hi,
                                          logic [31:0] base, logic [2:0] sh);
        logic [63:0] b = {hi, lo};
        for (int i = 0; i < 64; i++) begin
            if (b[i]) return {1'b1, base + (32'(i) << sh)};
        end
        return {1'b0, base};
    endfunction

    task automatic chk(string req, logic [32:0] act, logic [32:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b addr=%08h, expected valid=%0b addr=%08h",
                     req, act[32], act[31:0], exp[32], exp[31:0]);
        end
    endtask

    task automatic step(logic [31:0] lo, logic [31:0] hi, logic we,
                        logic sel, logic [31:0] data, string req);
        @(negedge clk);
        stat_lo = lo; stat_hi = hi;
        cfg_wr_en = we; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk);
        #1;
        chk(req, {vec_valid, vec_addr}, model(lo, hi, base_m, sh_m));
        if (we) begin
            if (sel) sh_m = data[2:0];
            else     base_m = data;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got no finish, expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_r;
        seed_r = $urandom(32'h5EED_0042);
        stat_lo = 32'hFFFF_0000; stat_hi = 32'h1;
        cfg_wr_en = 1'b1; cfg_wdata = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        chk("R7 reset outputs", {vec_valid, vec_addr}, 33'h0);
        @(negedge clk);
        cfg_wr_en = 1'b0;
        rst_n = 1'b1;

        // R7: configuration came out of reset at zero
        step(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R7 base zero");
        step(32'h20, 32'h0, 1'b0, 1'b0, 32'h0, "R7 shift zero");
        // R6: base write, compared result still uses the old base
        step(32'h0, 32'h0, 1'b1, 1'b0, 32'h0000_1000, "R6 write latency");
        step(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R4 idle equals base");
        // R6: shift write with junk in the upper bits
        step(32'h0, 32'h0, 1'b1, 1'b1, 32'hABCD_EF05, "R6 shift write");
        step(32'h8, 32'h0, 1'b0, 1'b0, 32'h0, "R2 id 3 shift 5");
        step(32'h0010_0080, 32'h1, 1'b0, 1'b0, 32'h0, "R1 lowest in low word");
        step(32'h0, 32'h8000_0001, 1'b0, 1'b0, 32'h0, "R1 high word id 32");
        step(32'h0, 32'h8000_0000, 1'b0, 1'b0, 32'h0, "R1 id 63");
        step(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0, "R1 id 31 beats high word");
        step(32'h1, 32'h0, 1'b0, 1'b0, 32'h0, "R1 id 0");
        step(32'h0, 32'h0, 1'b0, 1'b0, 32'h0, "R5 status drop");
        // R9: strobe low, data and select toggling
        step(32'h0, 32'h0, 1'b0, 1'b0, 32'hDEAD_BEEF, "R9 no write base");
        step(32'h0, 32'h0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R9 no write shift");
        step(32'h4, 32'h0, 1'b0, 1'b0, 32'h0, "R9 config kept");
        for (int k = 0; k < 8; k++) begin
            step(32'h0, 32'h0, 1'b1, 1'b1, 32'(k), "R3 set shift");
            step(32'h0, 32'h8000_0000, 1'b0, 1'b0, 32'h0, $sformatf("R3 shift %0d", k));
        end
        // R8: wrap past 2^32
        step(32'h0, 32'h0, 1'b1, 1'b0, 32'hFFFF_FFF0, "R8 set base");
        step(32'h0, 32'h0, 1'b1, 1'b1, 32'h7, "R8 set shift");
        step(32'h0, 32'h8000_0000, 1'b0, 1'b0, 32'h0, "R8 wrap");

        for (int n = 0; n < 400; n++) begin
            logic [31:0] lo, hi;
            int mode;
            mode = int'($urandom % 5);
            lo = $urandom; hi = $urandom;
            case (mode)
                0: begin lo = '0; hi = '0; end
                1: begin lo = 32'h1 << ($urandom % 32); hi = '0; end
                2: begin lo = '0; end
                3: begin lo = lo & $urandom & $urandom; hi = hi & $urandom; end
                default: ;
            endcase
            step(lo, hi, ($urandom % 4) == 0, $urandom % 2, $urandom,
                 (lo == 0 && hi == 0) ? "R4 random idle" : "R1/R2 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule